// File: doc/BRIEF.md
# Enhanced Parallel Port Handshake Engine

This block sits between a host register bus and a parallel port and turns each single host register read or write into one interlocked handshake on the port. The host holds a read or write strobe, together with a register select and write data, until the block's ready output comes back high. The select chooses between the data register and the address register. On the port side the block drives an 8-bit byte with a separate output enable, a direction pin, an active-low write line and two active-low strobes, one for data and one for address. It follows an active-low wait input from the peripheral.

Each transfer is fully interlocked. The engine does not touch the port until the peripheral holds wait low. It sets up the bus, the direction pin and the write line, then asserts the strobe that matches the selected register. It keeps the strobe low until the peripheral raises wait. Releasing the strobe and releasing host ready happen on the same clock edge. On a read, the port byte is captured on that edge as well. The transfer only closes when the peripheral pulls wait low again. Until then the port lines stay frozen and any new host request is kept waiting with ready low.

The wait input passes through a synchronizer of `SYNC_STAGES` flops. The bidirectional port bus is split into `pd_out`, `pd_in` and `pd_oe`. If the host raises both strobes at once, the write is carried out.

Top module: `epp_cycle_engine`

## Requirements
- R1: Host ready (`host_rdy`) is low from the clock in which a host strobe is seen until the port strobe is released, and it is never high while a port strobe is low and a host strobe is active.
- R2: No port strobe is asserted and the write line, direction pin and output enable keep their values while the peripheral holds `port_wait_n` high (deasserted) at the start of a transfer; the transfer proceeds once `port_wait_n` is low.
- R3: On a write, `pd_out` carries the host byte, `pd_oe` is 1, `pd_dir` is 0 and `port_write_n` is 0 at least one clock before the strobe goes low.
- R4: A port strobe stays low until `port_wait_n` goes high; the strobe then returns high, and host ready goes high on the same clock edge.
- R5: On a read, `pd_oe` is 0, `pd_dir` is 1 and `port_write_n` is 1 at least one clock before the strobe goes low.
- R6: On a read, the value on `pd_in` when the strobe is released appears on `host_rdata` while host ready is high, and a later change of `pd_in` does not alter it.
- R7: After the strobe is released, `port_write_n`, `pd_dir`, `pd_oe` and `pd_out` do not change and no strobe is asserted until `port_wait_n` is low again.
- R8: With `host_sel_addr` = 1 only `port_astb_n` goes low; with `host_sel_addr` = 0 only `port_dstb_n` goes low; the two are never low together.
- R9: A host request raised before the previous transfer is closed by wait going low sees `host_rdy` low and gets no strobe; it starts once the previous transfer closes.
- R10: During and right after reset, both strobes and `port_write_n` are 1, `pd_oe` is 0 and `host_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, held until ready |
| host_rd | input | 1 | Host read strobe, held until ready |
| host_sel_addr | input | 1 | 1 selects the address register, 0 the data register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte captured by the last port read |
| host_rdy | output | 1 | Host ready; low stretches the host access |
| pd_out | output | 8 | Port bus output value |
| pd_in | input | 8 | Port bus input value |
| pd_oe | output | 1 | Port bus output enable (1 drives `pd_out`) |
| pd_dir | output | 1 | Port direction pin (1 = peripheral to host) |
| port_write_n | output | 1 | Active-low write line |
| port_dstb_n | output | 1 | Active-low data strobe |
| port_astb_n | output | 1 | Active-low address strobe |
| port_wait_n | input | 1 | Active-low wait from the peripheral |

## Verification
The main sweep runs every byte value through each combination of direction and register select. This separates data-strobe from address-strobe selection, read setup from write setup, and correct capture of `pd_in` from a stale or mixed-up byte. Strobe hold lengths vary, and some transfers begin with wait still high, so the bench can tell a strobe that waits on the peripheral from one that follows a fixed delay. Chained transfers that raise a new host request before wait drops show whether the engine really waits for closure, rather than starting early on a new request.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam int unsigned EPP_DW = 8;

    typedef logic [EPP_DW-1:0] epp_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_TERM   = 3'd4
    } epp_state_e;

    // One captured host request
    typedef struct packed {
        logic      rd;
        logic      addr;
        epp_byte_t wbyte;
    } epp_req_t;

    // Registered port-side drive
    typedef struct packed {
        logic      write_n;
        logic      dir;
        logic      oe;
        epp_byte_t dout;
    } epp_drive_t;

    localparam epp_drive_t DRIVE_IDLE = '{write_n: 1'b1, dir: 1'b1, oe: 1'b0, dout: '0};

    function automatic epp_drive_t drive_for(input epp_req_t r);
        epp_drive_t d;
        d.write_n = r.rd;
        d.dir     = r.rd;
        d.oe      = ~r.rd;
        d.dout    = r.rd ? '0 : r.wbyte;
        return d;
    endfunction

    function automatic logic in_hold_window(input epp_state_e s);
        return (s == ST_STROBE) || (s == ST_TERM);
    endfunction

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/epp_ctrl_fsm.sv
module epp_ctrl_fsm
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_sel_addr,
    input  epp_byte_t  host_wdata,
    input  logic       wait_asserted,
    output epp_state_e state,
    output epp_req_t   cur,
    output logic       load_port,
    output logic       latch_rd,
    output logic       host_rdy,
    output logic       dstb_n,
    output logic       astb_n
);
    epp_state_e st_q;
    epp_req_t   cur_q;
    logic       released_q;
    logic       req_any;

    assign req_any = host_wr | host_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cur_q      <= '0;
            released_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_any) begin
                        cur_q      <= '{rd: ~host_wr, addr: host_sel_addr, wbyte: host_wdata};
                        released_q <= 1'b0;
                        st_q       <= ST_ARM;
                    end
                end
                ST_ARM:    if (wait_asserted) st_q <= ST_SETUP;
                ST_SETUP:  st_q <= ST_STROBE;
                ST_STROBE: if (!wait_asserted) st_q <= ST_TERM;
                ST_TERM: begin
                    if (!req_any) released_q <= 1'b1;
                    if (wait_asserted && (released_q || !req_any)) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state     = st_q;
    assign cur       = cur_q;
    assign load_port = (st_q == ST_ARM) && wait_asserted;
    assign latch_rd  = (st_q == ST_STROBE) && !wait_asserted && cur_q.rd;
    assign host_rdy  = !(req_any && !((st_q == ST_TERM) && !released_q));
    assign dstb_n    = !((st_q == ST_STROBE) && !cur_q.addr);
    assign astb_n    = !((st_q == ST_STROBE) && cur_q.addr);

    AST_STROBE_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        ($fell(dstb_n) || $fell(astb_n)) |-> $past(wait_asserted, 2)) else $error("strobe without wait"); // R2

    AST_TERM_WAITS_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TERM && !wait_asserted) |=> (st_q == ST_TERM)) else $error("closed early"); // R7
endmodule

// File: rtl/epp_port_regs.sv
module epp_port_regs
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       latch,
    input  logic       hold_window,
    input  epp_req_t   req,
    input  epp_byte_t  pd_in,
    output epp_drive_t drive,
    output epp_byte_t  rdata
);
    epp_drive_t drive_q;
    epp_byte_t  rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= DRIVE_IDLE;
            rdata_q <= '0;
        end else begin
            if (load)  drive_q <= drive_for(req);
            if (latch) rdata_q <= pd_in;
        end
    end

    assign drive = drive_q;
    assign rdata = rdata_q;

    AST_PORT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold_window |-> $stable(drive_q)) else $error("port lines moved"); // R7
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel_addr,
    input  logic [EPP_DW-1:0] host_wdata,
    output logic [EPP_DW-1:0] host_rdata,
    output logic              host_rdy,
    output logic [EPP_DW-1:0] pd_out,
    input  logic [EPP_DW-1:0] pd_in,
    output logic              pd_oe,
    output logic              pd_dir,
    output logic              port_write_n,
    output logic              port_dstb_n,
    output logic              port_astb_n,
    input  logic              port_wait_n
);
    logic       wait_sync_n;
    epp_state_e state;
    epp_req_t   cur;
    logic       load_port;
    logic       latch_rd;
    epp_drive_t drive;

    epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (port_wait_n),
        .sync_n  (wait_sync_n)
    );

    epp_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_sel_addr (host_sel_addr),
        .host_wdata    (host_wdata),
        .wait_asserted (!wait_sync_n),
        .state         (state),
        .cur           (cur),
        .load_port     (load_port),
        .latch_rd      (latch_rd),
        .host_rdy      (host_rdy),
        .dstb_n        (port_dstb_n),
        .astb_n        (port_astb_n)
    );

    epp_port_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .load        (load_port),
        .latch       (latch_rd),
        .hold_window (in_hold_window(state)),
        .req         (cur),
        .pd_in       (pd_in),
        .drive       (drive),
        .rdata       (host_rdata)
    );

    assign pd_out       = drive.dout;
    assign pd_oe        = drive.oe;
    assign pd_dir       = drive.dir;
    assign port_write_n = drive.write_n;

    AST_STROBE_BLOCKS_HOST: assert property (@(posedge clk) disable iff (rst)
        ((!port_dstb_n || !port_astb_n) && (host_wr || host_rd)) |-> !host_rdy) else $error("ready during strobe"); // R1

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($fell(port_dstb_n) || $fell(port_astb_n)) |->
            (port_write_n == cur.rd) && (pd_dir == cur.rd) && (pd_oe == !cur.rd) &&
            (cur.rd || pd_out == cur.wbyte)) else $error("bad setup"); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!port_dstb_n, !port_astb_n})) else $error("two strobes"); // R8

    AST_RDATA_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_STROBE && state == ST_TERM && cur.rd) |-> (host_rdata == $past(pd_in))) else $error("read capture"); // R6
endmodule

// File: tb/epp_cycle_engine_tb_top.sv
module epp_cycle_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr, host_rd, host_sel_addr;
    logic [7:0] host_wdata, host_rdata, pd_out, pd_in;
    logic       host_rdy, pd_oe, pd_dir, port_write_n, port_dstb_n, port_astb_n, port_wait_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    epp_cycle_engine dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel_addr(host_sel_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .pd_dir(pd_dir),
        .port_write_n(port_write_n), .port_dstb_n(port_dstb_n), .port_astb_n(port_astb_n),
        .port_wait_n(port_wait_n)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_cycle(input bit rd, input bit sel, input logic [7:0] b,
                            input bit pre_high, input int hold, input bit leave_high);
        logic       pw, pdr, po, lw, ld, lo;
        logic [7:0] lp, rv;
        bit         seen;
        rv = ~b;
        if (pre_high) begin
            port_wait_n = 1'b1;
            repeat (3) @(negedge clk);
        end else begin
            @(negedge clk);
        end
        pw = port_write_n; pdr = pd_dir; po = pd_oe;
        lw = pw; ld = pdr; lo = po; lp = pd_out;
        host_sel_addr = sel; host_wdata = b; host_wr = !rd; host_rd = rd;
        #1 chk(host_rdy == 1'b0, "R1 ready low on request", host_rdy, 0);
        if (pre_high) begin
            repeat (6) begin
                @(negedge clk);
                chk(port_dstb_n && port_astb_n && port_write_n == pw && pd_dir == pdr && pd_oe == po,
                    "R2 R9 port idle while wait high",
                    {port_dstb_n, port_astb_n, port_write_n, pd_dir, pd_oe}, {2'b11, pw, pdr, po});
                chk(!host_rdy, "R9 ready held low", host_rdy, 0);
            end
            port_wait_n = 1'b0;
        end
        seen = 0;
        for (int k = 0; k < 14 && !seen; k++) begin
            @(negedge clk);
            if (!port_dstb_n || !port_astb_n) seen = 1;
            else begin lw = port_write_n; ld = pd_dir; lo = pd_oe; lp = pd_out; end
        end
        chk(seen, "R2 strobe issued once wait low", seen, 1);
        chk(port_astb_n == !sel && port_dstb_n == sel, "R8 strobe select",
            {port_astb_n, port_dstb_n}, {!sel, sel});
        if (!rd)
            chk(lw == 0 && ld == 0 && lo == 1 && lp == b, "R3 write setup before strobe",
                {lw, ld, lo, lp}, {3'b001, b});
        else
            chk(lw == 1 && ld == 1 && lo == 0, "R5 read setup before strobe",
                {lw, ld, lo}, 3'b110);
        chk(!host_rdy, "R1 ready low while strobing", host_rdy, 0);
        repeat (hold) begin
            @(negedge clk);
            chk(!(port_dstb_n && port_astb_n), "R4 strobe held until wait high",
                {port_dstb_n, port_astb_n}, {sel, !sel});
        end
        if (rd) pd_in = rv;
        port_wait_n = 1'b1;
        seen = 0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (port_dstb_n && port_astb_n) seen = 1;
            else chk(!host_rdy, "R1 ready low before release", host_rdy, 0);
        end
        chk(seen, "R4 strobe released after wait high", seen, 1);
        chk(host_rdy, "R4 ready released with strobe", host_rdy, 1);
        if (rd) chk(host_rdata == rv, "R6 read byte captured", host_rdata, rv);
        pd_in = b;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk(port_dstb_n && port_astb_n && port_write_n == rd && pd_dir == rd && pd_oe == !rd,
                "R7 port frozen until wait low",
                {port_dstb_n, port_astb_n, port_write_n, pd_dir, pd_oe}, {2'b11, rd, rd, !rd});
            if (!rd) chk(pd_out == b, "R7 write byte held", pd_out, b);
            else     chk(host_rdata == rv, "R6 captured byte kept", host_rdata, rv);
        end
        if (!leave_high) begin
            port_wait_n = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
    end

    initial begin
        rst = 1'b1; host_wr = 0; host_rd = 0; host_sel_addr = 0; host_wdata = '0;
        pd_in = '0; port_wait_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(port_dstb_n && port_astb_n && port_write_n && !pd_oe && host_rdy, "R10 reset state",
            {port_dstb_n, port_astb_n, port_write_n, pd_oe, host_rdy}, 5'b11101);
        rst = 1'b0;
        @(negedge clk);
        chk(port_dstb_n && port_astb_n && port_write_n && !pd_oe && host_rdy, "R10 after reset",
            {port_dstb_n, port_astb_n, port_write_n, pd_oe, host_rdy}, 5'b11101);
        port_wait_n = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 1024; i++) begin
            logic [9:0] iv;
            iv = i[9:0];
            do_cycle(iv[0], iv[1], iv[9:2], (i % 7) == 3, i % 3, 1'b0);
        end

        // chained requests raised before the previous transfer closes (R9)
        do_cycle(1'b0, 1'b0, 8'hA5, 1'b0, 1, 1'b1);
        do_cycle(1'b1, 1'b1, 8'h3C, 1'b1, 0, 1'b0);
        do_cycle(1'b1, 1'b0, 8'hC3, 1'b0, 0, 1'b1);
        do_cycle(1'b0, 1'b1, 8'h81, 1'b1, 2, 1'b0);

        summary();
    end
endmodule